// File: doc/BRIEF.md
# Vector Load/Store Address Sequencer

This block walks the element positions of a single vectorised load or store and emits one effective address for every element that the predicate masks leave active. A start pulse captures the whole access description: the addressing mode, whether the offset comes from an immediate or from a second register, the access size, the vector length, the two predicate masks and a vector/scalar flag for each register operand. After the start, the sequencer presents one element at a time to the memory port under a valid/ready handshake. It reports the source, offset, destination and update register indices it used, so the surrounding register file returns the operand values on `ra_data_i` and `rb_data_i` in the same cycle.

Four addressing modes exist. Unit-stride steps the address by the access size. Element-stride multiplies the offset by the element number. Indexed adds a per-element base to a per-element offset. Scalar-splat repeats one address for every destination element. A register-sourced offset can be narrowed to a source element width and optionally sign-extended. Post-increment presents the un-offset base to memory and returns the offset sum as the value for the update register.

Top module: `vlsu_addr_seq`

## Requirements
- R1: After reset, `busy_o`, `valid_o` and `done_o` are all 0.
- R2: `start_i` is taken only while `busy_o` is 0. A start pulse, or a change of any configuration input, while busy leaves the running sequence unchanged.
- R3: Mode code 0 (unit-stride): `ea_o` = ra + off + j·2^w. Here j is `dst_idx_o`, w is `op_width_i` (0..3 meaning 1, 2, 4, 8 bytes), and off is the selected offset.
- R4: Mode code 1 (element-stride): `ea_o` = ra + off·j. With an immediate of zero every element uses the same address. With a register offset and both sources scalar, the offset register is scaled by the destination index.
- R5: Mode code 2 (indexed): `ea_o` = ra + off, with ra read at `src_idx_o` and the offset register read at `off_idx_o`.
- R6: Mode code 3 (scalar-splat): `src_idx_o` and `off_idx_o` stay 0 whatever the vector flags say, and `ea_o` = ra + off for every element.
- R7: A vector-flagged index only lands on positions whose mask bit is 1. Source, offset and update indices use `src_mask_i`; the destination index uses `dst_mask_i`. An index whose operand is scalar stays 0.
- R8: When the destination is scalar (`rt_vec_i`=0), the sequence ends after the first accepted element.
- R9: With `postinc_i`=1, `ea_o` is the base term without the offset, and `upd_val_o` is base plus offset. Without it, `upd_val_o` equals `ea_o`.
- R10: With `off_reg_i`=1, the offset is `rb_data_i` cut to `src_ew_i` bits (0:8, 1:16, 2:32, 3:64). It is sign-extended only when `sea_i`=1 in mode 2, and zero-extended otherwise. With `off_reg_i`=0, the offset is `imm_i`.
- R11: While `valid_o`=1 and `ready_i`=0, the address and indices hold. At most one element is accepted per cycle.
- R12: Once any vector-flagged index reaches the vector length, or `vl_i` was 0, or the scalar destination has finished, `done_o` is 1 for one cycle with `valid_o`=0, and the block then returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a sequence (taken when idle) |
| mode_i | input | 2 | 0 unit, 1 element, 2 indexed, 3 splat |
| off_reg_i | input | 1 | Offset from register instead of immediate |
| postinc_i | input | 1 | Post-increment update |
| sea_i | input | 1 | Sign-extend register offset in indexed mode |
| src_ew_i | input | 2 | Source element width code |
| op_width_i | input | 2 | log2 of access size in bytes |
| vl_i | input | IDXW | Vector length |
| src_mask_i | input | MAXVL | Source predicate mask |
| dst_mask_i | input | MAXVL | Destination predicate mask |
| ra_vec_i | input | 1 | Base operand is a vector |
| rb_vec_i | input | 1 | Offset operand is a vector |
| rt_vec_i | input | 1 | Destination is a vector |
| upd_vec_i | input | 1 | Update register is a vector |
| imm_i | input | AW | Immediate offset |
| ra_data_i | input | AW | Base register value at `src_idx_o` |
| rb_data_i | input | AW | Offset register value at `off_idx_o` |
| ready_i | input | 1 | Memory port accepts the element |
| valid_o | output | 1 | Element address presented |
| ea_o | output | AW | Effective address |
| src_idx_o | output | IDXW | Base register element index |
| off_idx_o | output | IDXW | Offset register element index |
| dst_idx_o | output | IDXW | Destination element index |
| upd_idx_o | output | IDXW | Update register element index |
| upd_val_o | output | AW | Value for the update register |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |

## Verification
A start taken at one rising edge makes the first element, or `done_o` for an empty sequence, visible right after that same edge. Each element accepted at an edge is replaced by the next one right after that edge, and `busy_o` falls one edge after `done_o`. Address and update values come from `ra_data_i` and `rb_data_i` through logic with no register, so they are valid in the same cycle as the indices. The bench therefore drives all inputs and samples all outputs on the falling edge. It advances its own element model only after a cycle in which it held `ready_i` high, and it compares every field each cycle, which also covers stalled cycles.

// File: rtl/vlsu_seq_pkg.sv
package vlsu_seq_pkg;

    typedef enum logic [1:0] {
        AM_UNIT  = 2'd0,
        AM_ELEM  = 2'd1,
        AM_INDEX = 2'd2,
        AM_SPLAT = 2'd3
    } addr_mode_e;

    localparam int NLANE   = 4;
    localparam int LN_SRC  = 0;
    localparam int LN_OFF  = 1;
    localparam int LN_DST  = 2;
    localparam int LN_UPD  = 3;

endpackage

// File: rtl/vlsu_first_set.sv
// Lowest set mask position at or above a start index; MAXVL when none.
module vlsu_first_set #(
    parameter int MAXVL = 16,
    parameter int IDXW  = $clog2(MAXVL + 1)
) (
    input  logic [MAXVL-1:0] mask_i,
    input  logic [IDXW-1:0]  from_i,
    output logic [IDXW-1:0]  pos_o
);
    always_comb begin
        pos_o = IDXW'(MAXVL);
        for (int p = MAXVL - 1; p >= 0; p--) begin
            if (mask_i[p] && (IDXW'(p) >= from_i)) begin
                pos_o = IDXW'(p);
            end
        end
    end
endmodule

// File: rtl/vlsu_ea_calc.sv
// Combinational effective-address and update-value computation.
module vlsu_ea_calc
    import vlsu_seq_pkg::*;
#(
    parameter int AW   = 64,
    parameter int IDXW = 5
) (
    input  addr_mode_e       mode_i,
    input  logic             off_reg_i,
    input  logic             postinc_i,
    input  logic             sea_i,
    input  logic [1:0]       src_ew_i,
    input  logic [1:0]       op_width_i,
    input  logic [AW-1:0]    imm_i,
    input  logic [AW-1:0]    ra_i,
    input  logic [AW-1:0]    rb_i,
    input  logic [IDXW-1:0]  dst_idx_i,
    output logic [AW-1:0]    ea_o,
    output logic [AW-1:0]    upd_o
);
    logic          sgn;
    logic [AW-1:0] rb_ext;
    logic [AW-1:0] off;
    logic [AW-1:0] jz;
    logic [AW-1:0] base_t;
    logic [AW-1:0] off_t;
    logic [AW-1:0] sum;

    assign sgn = sea_i && (mode_i == AM_INDEX);

    always_comb begin
        unique case (src_ew_i)
            2'd0:    rb_ext = sgn ? {{(AW-8){rb_i[7]}},   rb_i[7:0]}
                                  : {{(AW-8){1'b0}},      rb_i[7:0]};
            2'd1:    rb_ext = sgn ? {{(AW-16){rb_i[15]}}, rb_i[15:0]}
                                  : {{(AW-16){1'b0}},     rb_i[15:0]};
            2'd2:    rb_ext = sgn ? {{(AW-32){rb_i[31]}}, rb_i[31:0]}
                                  : {{(AW-32){1'b0}},     rb_i[31:0]};
            default: rb_ext = rb_i;
        endcase
    end

    assign off    = off_reg_i ? rb_ext : imm_i;
    assign jz     = AW'(dst_idx_i);
    assign base_t = ra_i + ((mode_i == AM_UNIT) ? (jz << op_width_i) : '0);
    assign off_t  = (mode_i == AM_ELEM) ? (off * jz) : off;
    assign sum    = base_t + off_t;
    assign ea_o   = postinc_i ? base_t : sum;
    assign upd_o  = sum;
endmodule

// File: rtl/vlsu_addr_seq.sv
module vlsu_addr_seq
    import vlsu_seq_pkg::*;
#(
    parameter int AW    = 64,
    parameter int MAXVL = 16,
    parameter int IDXW  = $clog2(MAXVL + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [1:0]       mode_i,
    input  logic             off_reg_i,
    input  logic             postinc_i,
    input  logic             sea_i,
    input  logic [1:0]       src_ew_i,
    input  logic [1:0]       op_width_i,
    input  logic [IDXW-1:0]  vl_i,
    input  logic [MAXVL-1:0] src_mask_i,
    input  logic [MAXVL-1:0] dst_mask_i,
    input  logic             ra_vec_i,
    input  logic             rb_vec_i,
    input  logic             rt_vec_i,
    input  logic             upd_vec_i,
    input  logic [AW-1:0]    imm_i,
    input  logic [AW-1:0]    ra_data_i,
    input  logic [AW-1:0]    rb_data_i,
    input  logic             ready_i,
    output logic             valid_o,
    output logic [AW-1:0]    ea_o,
    output logic [IDXW-1:0]  src_idx_o,
    output logic [IDXW-1:0]  off_idx_o,
    output logic [IDXW-1:0]  dst_idx_o,
    output logic [IDXW-1:0]  upd_idx_o,
    output logic [AW-1:0]    upd_val_o,
    output logic             busy_o,
    output logic             done_o
);
    typedef struct packed {
        logic                        busy;
        logic                        fin;
        addr_mode_e                  mode;
        logic                        off_reg;
        logic                        postinc;
        logic                        sea;
        logic [1:0]                  src_ew;
        logic [1:0]                  op_w;
        logic [IDXW-1:0]             vl;
        logic [MAXVL-1:0]            smask;
        logic [MAXVL-1:0]            dmask;
        logic [NLANE-1:0]            vec;
        logic [AW-1:0]               imm;
        logic [NLANE-1:0][IDXW-1:0]  idx;
    } seq_state_t;

    seq_state_t st_d, st_q;

    logic                        splat_in;
    logic [NLANE-1:0]            vec_in;
    logic [NLANE-1:0][IDXW-1:0]  first0;
    logic [NLANE-1:0][IDXW-1:0]  nxt;
    logic [NLANE-1:0]            over;
    logic                        exhausted;
    logic                        accept;

    assign splat_in = (mode_i == 2'd3);
    assign vec_in   = {upd_vec_i, rt_vec_i, rb_vec_i && !splat_in, ra_vec_i && !splat_in};

    // One skip finder pair per index lane: first live slot at start, next live slot on accept.
    for (genvar l = 0; l < NLANE; l++) begin : g_lane
        if (l == LN_DST) begin : g_dst
            vlsu_first_set #(.MAXVL(MAXVL), .IDXW(IDXW)) u_first (
                .mask_i (dst_mask_i),
                .from_i ('0),
                .pos_o  (first0[l])
            );
            vlsu_first_set #(.MAXVL(MAXVL), .IDXW(IDXW)) u_next (
                .mask_i (st_q.dmask),
                .from_i (st_q.idx[l] + IDXW'(1)),
                .pos_o  (nxt[l])
            );
        end else begin : g_src
            vlsu_first_set #(.MAXVL(MAXVL), .IDXW(IDXW)) u_first (
                .mask_i (src_mask_i),
                .from_i ('0),
                .pos_o  (first0[l])
            );
            vlsu_first_set #(.MAXVL(MAXVL), .IDXW(IDXW)) u_next (
                .mask_i (st_q.smask),
                .from_i (st_q.idx[l] + IDXW'(1)),
                .pos_o  (nxt[l])
            );
        end
        assign over[l] = st_q.vec[l] && (st_q.idx[l] >= st_q.vl);
    end

    assign exhausted = st_q.fin || (st_q.vl == '0) || (|over);
    assign valid_o   = st_q.busy && !exhausted;
    assign done_o    = st_q.busy && exhausted;
    assign accept    = valid_o && ready_i;

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (start_i) begin
                st_d.busy    = 1'b1;
                st_d.fin     = 1'b0;
                st_d.mode    = addr_mode_e'(mode_i);
                st_d.off_reg = off_reg_i;
                st_d.postinc = postinc_i;
                st_d.sea     = sea_i;
                st_d.src_ew  = src_ew_i;
                st_d.op_w    = op_width_i;
                st_d.vl      = vl_i;
                st_d.smask   = src_mask_i;
                st_d.dmask   = dst_mask_i;
                st_d.vec     = vec_in;
                st_d.imm     = imm_i;
                for (int l = 0; l < NLANE; l++) begin
                    st_d.idx[l] = vec_in[l] ? first0[l] : '0;
                end
            end
        end else if (exhausted) begin
            st_d.busy = 1'b0;
            st_d.fin  = 1'b0;
        end else if (accept) begin
            for (int l = 0; l < NLANE; l++) begin
                if (st_q.vec[l]) begin
                    st_d.idx[l] = nxt[l];
                end
            end
            if (!st_q.vec[LN_DST]) begin
                st_d.fin = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    vlsu_ea_calc #(.AW(AW), .IDXW(IDXW)) u_ea (
        .mode_i     (st_q.mode),
        .off_reg_i  (st_q.off_reg),
        .postinc_i  (st_q.postinc),
        .sea_i      (st_q.sea),
        .src_ew_i   (st_q.src_ew),
        .op_width_i (st_q.op_w),
        .imm_i      (st_q.imm),
        .ra_i       (ra_data_i),
        .rb_i       (rb_data_i),
        .dst_idx_i  (st_q.idx[LN_DST]),
        .ea_o       (ea_o),
        .upd_o      (upd_val_o)
    );

    assign src_idx_o = st_q.idx[LN_SRC];
    assign off_idx_o = st_q.idx[LN_OFF];
    assign dst_idx_o = st_q.idx[LN_DST];
    assign upd_idx_o = st_q.idx[LN_UPD];
    assign busy_o    = st_q.busy;

    // ---------------- assertions ----------------
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!valid_o && !done_o));

    p_cfg_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> ($stable(st_q.vl) && $stable(st_q.mode) && $stable(st_q.imm)));

    p_splat_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && st_q.mode == AM_SPLAT) |-> (src_idx_o == '0 && off_idx_o == '0));

    p_dst_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && st_q.vec[LN_DST]) |-> st_q.dmask[dst_idx_o]);

    p_src_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && st_q.vec[LN_SRC]) |-> st_q.smask[src_idx_o]);

    p_scalar_dst_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !st_q.vec[LN_DST]) |=> !valid_o);

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i) |=> (valid_o && $stable(dst_idx_o) && $stable(src_idx_o)
                                  && $stable(off_idx_o)));

    p_advance_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && st_q.vec[LN_DST]) |=> (!valid_o || dst_idx_o > $past(dst_idx_o)));

    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!busy_o && !done_o));

endmodule

// File: tb/vlsu_addr_seq_bench.sv
`timescale 1ns/1ps
module vlsu_addr_seq_bench;
    localparam int AW    = 64;
    localparam int MAXVL = 16;
    localparam int IDXW  = $clog2(MAXVL + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [1:0]       mode_i = '0;
    logic             off_reg_i = 1'b0, postinc_i = 1'b0, sea_i = 1'b0;
    logic [1:0]       src_ew_i = '0, op_width_i = '0;
    logic [IDXW-1:0]  vl_i = '0;
    logic [MAXVL-1:0] src_mask_i = '0, dst_mask_i = '0;
    logic             ra_vec_i = 1'b0, rb_vec_i = 1'b0, rt_vec_i = 1'b0, upd_vec_i = 1'b0;
    logic [AW-1:0]    imm_i = '0;
    logic [AW-1:0]    ra_data_i, rb_data_i;
    logic             ready_i = 1'b0;
    logic             valid_o, busy_o, done_o;
    logic [AW-1:0]    ea_o, upd_val_o;
    logic [IDXW-1:0]  src_idx_o, off_idx_o, dst_idx_o, upd_idx_o;

    logic [AW-1:0] ra_rf [MAXVL];
    logic [AW-1:0] rb_rf [MAXVL];

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit ended  = 0;

    always #2.5 clk = ~clk;

    assign ra_data_i = (int'(src_idx_o) < MAXVL) ? ra_rf[int'(src_idx_o)] : '0;
    assign rb_data_i = (int'(off_idx_o) < MAXVL) ? rb_rf[int'(off_idx_o)] : '0;

    vlsu_addr_seq #(.AW(AW), .MAXVL(MAXVL)) u_vlsu_addr_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .off_reg_i(off_reg_i), .postinc_i(postinc_i), .sea_i(sea_i),
        .src_ew_i(src_ew_i), .op_width_i(op_width_i), .vl_i(vl_i),
        .src_mask_i(src_mask_i), .dst_mask_i(dst_mask_i),
        .ra_vec_i(ra_vec_i), .rb_vec_i(rb_vec_i), .rt_vec_i(rt_vec_i),
        .upd_vec_i(upd_vec_i), .imm_i(imm_i), .ra_data_i(ra_data_i),
        .rb_data_i(rb_data_i), .ready_i(ready_i), .valid_o(valid_o),
        .ea_o(ea_o), .src_idx_o(src_idx_o), .off_idx_o(off_idx_o),
        .dst_idx_o(dst_idx_o), .upd_idx_o(upd_idx_o), .upd_val_o(upd_val_o),
        .busy_o(busy_o), .done_o(done_o)
    );

    task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int skipb(input logic [MAXVL-1:0] m, input int from);
        for (int p = from; p < MAXVL; p++) if (m[p]) return p;
        return MAXVL;
    endfunction

    // R10: offset narrowing and extension
    function automatic logic [AW-1:0] off_of(input logic reg_f, input logic sgn,
                                             input logic [1:0] ew, input logic [AW-1:0] rb,
                                             input logic [AW-1:0] imm);
        logic [AW-1:0] v;
        int bits;
        if (!reg_f) return imm;
        bits = 8 << ew;
        v = rb;
        for (int b = bits; b < AW; b++) v[b] = sgn ? rb[bits-1] : 1'b0;
        return v;
    endfunction

    task automatic cfg(input int md, input bit rf, input bit pi, input bit se,
                       input int ew, input int ow, input int vl,
                       input logic [MAXVL-1:0] sm, input logic [MAXVL-1:0] dm,
                       input bit av, input bit bv, input bit tv, input bit uv,
                       input logic [AW-1:0] imm);
        mode_i = 2'(md); off_reg_i = rf; postinc_i = pi; sea_i = se;
        src_ew_i = 2'(ew); op_width_i = 2'(ow); vl_i = IDXW'(vl);
        src_mask_i = sm; dst_mask_i = dm; ra_vec_i = av; rb_vec_i = bv;
        rt_vec_i = tv; upd_vec_i = uv; imm_i = imm;
    endtask

    task automatic run(input bit poke, input bit full_ready);
        int md = int'(mode_i);
        bit rf = off_reg_i, pi = postinc_i, se = sea_i;
        int ew = int'(src_ew_i), ow = int'(op_width_i), vl = int'(vl_i);
        logic [MAXVL-1:0] sm = src_mask_i, dm = dst_mask_i;
        logic [AW-1:0] imm = imm_i;
        bit vi = ra_vec_i && md != 3, vk = rb_vec_i && md != 3;
        bit vj = rt_vec_i, vu = upd_vec_i;
        int ei, ek, ej, eu, n;
        bit fin, exh, rdy;
        string tag;
        logic [AW-1:0] ra, off, base, offt, sum;
        tag = (md == 0) ? "R3" : (md == 1) ? "R4" : (md == 2) ? "R5" : "R6";
        ei = vi ? skipb(sm, 0) : 0;
        ek = vk ? skipb(sm, 0) : 0;
        ej = vj ? skipb(dm, 0) : 0;
        eu = vu ? skipb(sm, 0) : 0;
        fin = 0; n = 0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int step = 0; step < 400; step++) begin
            exh = fin || vl == 0 || (vi && ei >= vl) || (vk && ek >= vl)
                  || (vj && ej >= vl) || (vu && eu >= vl);
            if (exh) begin
                chk("R12 done", 64'(done_o), 1);
                chk("R12 valid low at end", 64'(valid_o), 0);
                ready_i = 1'b0;
                @(negedge clk);
                chk("R12 idle after done", 64'(busy_o), 0);
                return;
            end
            chk("R11 valid", 64'(valid_o), 1);
            chk("R12 no early done", 64'(done_o), 0);
            chk("R7 src idx", 64'(src_idx_o), 64'(ei));
            chk("R7 off idx", 64'(off_idx_o), 64'(ek));
            chk("R7 dst idx", 64'(dst_idx_o), 64'(ej));
            chk("R7 upd idx", 64'(upd_idx_o), 64'(eu));
            ra   = ra_rf[ei];
            off  = off_of(rf, se && md == 2, 2'(ew), rb_rf[ek], imm);
            base = ra + ((md == 0) ? (64'(ej) << ow) : 64'd0);
            offt = (md == 1) ? off * 64'(ej) : off;
            sum  = base + offt;
            chk(pi ? "R9 ea" : (rf ? {tag, " R10 ea"} : tag), ea_o, pi ? base : sum);
            chk("R9 upd", upd_val_o, sum);
            if (poke && n == 1) begin
                start_i = 1'b1;
                vl_i = IDXW'(1);
                imm_i = ~imm;
            end
            rdy = full_ready || ($urandom % 4 != 0);
            ready_i = rdy;
            @(negedge clk);
            start_i = 1'b0;
            if (rdy) begin
                if (vi) ei = skipb(sm, ei + 1);
                if (vk) ek = skipb(sm, ek + 1);
                if (vj) ej = skipb(dm, ej + 1);
                if (vu) eu = skipb(sm, eu + 1);
                if (!vj) begin
                    fin = 1;
                    chk("R8 scalar dst ends", 64'(valid_o), 0);
                end
                n++;
            end
        end
        chk("R12 sequence terminates", 0, 1);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !ended) begin
            ended = 1;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        for (int r = 0; r < MAXVL; r++) begin
            ra_rf[r] = {$urandom, $urandom};
            rb_rf[r] = {$urandom, $urandom};
        end
        repeat (3) @(negedge clk);
        chk("R1 busy", 64'(busy_o), 0);
        chk("R1 valid", 64'(valid_o), 0);
        chk("R1 done", 64'(done_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 unit stride, 8-byte, full mask, scalar base
        cfg(0, 0, 0, 0, 3, 3, 4, '1, '1, 0, 0, 1, 0, 64'h10);
        run(0, 1);
        // R4 zero immediate: same address each element
        cfg(1, 0, 0, 0, 3, 2, 5, '1, 16'h00F5, 0, 0, 1, 0, 64'h0);
        run(0, 0);
        // R4 register-strided by destination index
        cfg(1, 1, 0, 0, 3, 0, 6, '1, 16'h003B, 0, 0, 1, 0, 64'h0);
        run(0, 0);
        // R5 indexed vector with predicate gaps, R7
        cfg(2, 1, 0, 0, 3, 0, 12, 16'h0A5A, 16'h0F0F, 1, 1, 1, 1, 64'h0);
        run(0, 0);
        // R10 sign extension of an 8-bit offset in indexed mode
        rb_rf[0] = 64'h00000000_000000F0;
        cfg(2, 1, 0, 1, 0, 0, 1, '1, '1, 0, 0, 1, 0, 64'h0);
        run(0, 1);
        // R10 same offset zero-extended outside indexed mode
        cfg(3, 1, 0, 1, 0, 0, 3, '1, '1, 1, 1, 1, 0, 64'h0);
        run(0, 1);
        // R8 scalar destination
        cfg(2, 0, 0, 0, 3, 0, 8, '1, '1, 1, 0, 0, 0, 64'h40);
        run(0, 1);
        // R12 zero vector length
        cfg(0, 0, 0, 0, 3, 0, 0, '1, '1, 0, 0, 1, 0, 64'h8);
        run(0, 1);
        // R9 post-increment
        cfg(0, 0, 1, 0, 3, 1, 4, '1, 16'h000D, 0, 0, 1, 1, 64'h20);
        run(0, 0);
        // R2 start and config change while busy are ignored
        cfg(2, 0, 0, 0, 3, 0, 6, '1, '1, 1, 0, 1, 1, 64'h100);
        run(1, 1);

        for (int t = 0; t < 200; t++) begin
            cfg(int'($urandom % 4), bit'($urandom), bit'($urandom % 3 == 0),
                bit'($urandom), int'($urandom % 4), int'($urandom % 4),
                int'($urandom % (MAXVL + 1)),
                16'($urandom) | 16'($urandom), 16'($urandom) | 16'($urandom),
                bit'($urandom), bit'($urandom), bit'($urandom % 4 != 0),
                bit'($urandom),
                ($urandom % 5 == 0) ? 64'h0 : {$urandom, $urandom});
            run(bit'($urandom % 8 == 0), 0);
        end

        if (!ended) begin
            ended = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule